// File: doc/BRIEF.md
# Transmitter Run/Stop Controller

This block owns the enable and stop control bits of a frame transmitter. It decides when the transmitter may begin a new frame, and it brings the transmitter to a clean halt. When the host asks for a halt, frames that have already started are allowed to finish. The block waits until the transmit status of every frame that has started has been written. It then clears both control bits on its own and raises a stop interrupt for a single cycle.

The frame data path and any queue purges sit outside the block. The block sees them only through two handshakes. One says that a start-of-frame command is waiting to be launched. The other says that a frame's status word has been written. The block grants each launch with a one-cycle start strobe and counts the frames whose status is still outstanding, up to a parameterised limit. After a halt, the host sets the enable bit again and any frame still waiting in the queue is launched.

Top module: `txq_halt_ctrl`

## Requirements
- R1: After reset, all of these outputs are 0: `tx_on`, `tx_stop`, `stop_irq`, `inflight` and `frame_start`.
- R2: A pulse on `host_on_set` makes `tx_on` read 1 from the next cycle on. `frame_start` is 1 in any cycle where all four hold at once: `tx_on` is 1, `tx_stop` is 0, `sof_ready` is 1 and `inflight` is below MAX_INFLIGHT.
- R3: Each `frame_start` adds one to `inflight` in the next cycle, and each `status_wr` takes one away. When both occur in the same cycle, the count does not change. A `status_wr` while `inflight` is 0 is ignored and the count stays at 0.
- R4: A pulse on `host_stop_set` makes `tx_stop` read 1 from the next cycle on. While `tx_stop` is 1, `frame_start` stays 0, even when `sof_ready` is 1.
- R5: `tx_stop` stays 1 as long as `inflight` is non-zero. In the cycle after a cycle in which `tx_stop` is 1 and `inflight` is 0, the stop completes: `tx_stop` and `tx_on` both read 0 and `stop_irq` reads 1.
- R6: `stop_irq` is never 1 for two cycles in a row.
- R7: Suppose `host_stop_set` pulses in cycle t while `inflight` is 0. Then `tx_stop` reads 1 in cycle t+1, and in cycle t+2 `stop_irq` reads 1 with both control bits cleared.
- R8: Suppose `host_on_set` pulses in the cycle in which the stop completes. Then `tx_on` stays 1 afterwards, `tx_stop` clears, and `stop_irq` still pulses.
- R9: After a stop, a frame still waiting (`sof_ready` held at 1) is launched with `frame_start` in the first cycle in which `tx_on` reads 1 again.
- R10: A `host_stop_set` pulse in the cycle in which the stop completes has no effect: `tx_stop` reads 0 in the following cycle.
- R11: `inflight` never exceeds MAX_INFLIGHT, and `frame_start` is 0 while `inflight` equals MAX_INFLIGHT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_on_set | input | 1 | Host write that sets the enable bit (one-cycle pulse) |
| host_stop_set | input | 1 | Host write that sets the stop bit (one-cycle pulse) |
| sof_ready | input | 1 | A start-of-frame command is waiting to be launched |
| status_wr | input | 1 | A transmit status word was written for a started frame |
| frame_start | output | 1 | Launch strobe for the waiting frame |
| tx_on | output | 1 | Enable bit |
| tx_stop | output | 1 | Stop bit (a halt is pending) |
| stop_irq | output | 1 | One-cycle stop interrupt |
| inflight | output | $clog2(MAX_INFLIGHT+1) | Started frames whose status has not yet been written |

## Verification
The bench builds the block with MAX_INFLIGHT set to 2. With that limit, two frames can be in flight at once, so a stop can be held open across two status writes, and the count can reach its ceiling while `sof_ready` stays high. The bench also drives the completion cycle on purpose, with competing enable and stop writes in that cycle, and it sends status writes while nothing is outstanding.

// File: rtl/txq_halt_pkg.sv
// Package txq_halt_pkg
// Holds the types shared by the run/stop controller and its sub-blocks.
// Assumes nothing beyond a single clock domain.
package txq_halt_pkg;

    // Packed view of the two host-visible control bits.
    typedef struct packed {
        logic on;
        logic stop;
    } txq_ctl_t;

    // Control value that reset puts in place.
    localparam txq_ctl_t TXQ_CTL_RESET = '{on: 1'b0, stop: 1'b0};

endpackage

// File: rtl/txq_inflight_cnt.sv
// Module txq_inflight_cnt
// Keeps a count of frames that have started but whose status is not yet written.
// Assumes the caller never raises inc while the count is full.
// A dec while the count is empty is dropped.
module txq_inflight_cnt #(
    parameter int MAX_INFLIGHT = 1,
    localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             empty,
    output logic             full
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_INFLIGHT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             take_inc;
    logic             take_dec;

    // Status flags derived from the current count.
    always_comb begin
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_MAX);
    end

    // Next count: launches add one, status writes take one away.
    always_comb begin
        take_inc = inc & ~full;
        take_dec = dec & ~empty;
        unique case ({take_inc, take_dec})
            2'b10:   cnt_d = cnt_q + CNT_ONE;
            2'b01:   cnt_d = cnt_q - CNT_ONE;
            default: cnt_d = cnt_q;
        endcase
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/txq_ctl_bits.sv
// Module txq_ctl_bits
// Holds the enable and stop bits and produces the one-cycle stop interrupt.
// Assumes drained is high exactly when no frame is in flight.
// The stop completes in the cycle where the stop bit is set and drained is high.
// When it completes, a simultaneous enable write wins over the hardware clear,
// and a simultaneous stop write is absorbed.
module txq_ctl_bits
    import txq_halt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     on_set,
    input  logic     stop_set,
    input  logic     drained,
    output txq_ctl_t ctl,
    output logic     irq
);

    txq_ctl_t ctl_q;
    txq_ctl_t ctl_d;
    logic     irq_q;
    logic     finish;

    // Completion test: a stop is pending and nothing is left in flight.
    always_comb begin
        finish = ctl_q.stop & drained;
    end

    // Next value of each control bit.
    always_comb begin
        ctl_d = ctl_q;
        if (finish) begin
            ctl_d.stop = 1'b0;
            ctl_d.on   = 1'b0;
        end else if (stop_set) begin
            ctl_d.stop = 1'b1;
        end
        if (on_set) begin
            ctl_d.on = 1'b1;
        end
    end

    // Control and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= TXQ_CTL_RESET;
            irq_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            irq_q <= finish;
        end
    end

    assign ctl = ctl_q;
    assign irq = irq_q;

endmodule

// File: rtl/txq_launch_gate.sv
// Module txq_launch_gate
// Decides whether a waiting frame may launch in this cycle.
// Assumes the ctl bits and the full flag are register outputs.
// The result depends on sof_ready in the same cycle.
module txq_launch_gate
    import txq_halt_pkg::*;
(
    input  txq_ctl_t ctl,
    input  logic     sof_ready,
    input  logic     full,
    output logic     launch
);

    // A launch needs the enable bit set, no stop pending, a waiting frame and a free slot.
    always_comb begin
        launch = ctl.on & ~ctl.stop & sof_ready & ~full;
    end

endmodule

// File: rtl/txq_halt_ctrl.sv
// Module txq_halt_ctrl
// Run/stop control for a frame transmitter. It launches waiting frames while
// enabled. On a stop request it lets started frames finish, then clears both
// control bits and pulses stop_irq for one cycle.
// Assumes status_wr arrives once for each frame started and never before it.
module txq_halt_ctrl
    import txq_halt_pkg::*;
#(
    parameter int MAX_INFLIGHT = 1,
    localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_on_set,
    input  logic             host_stop_set,
    input  logic             sof_ready,
    input  logic             status_wr,
    output logic             frame_start,
    output logic             tx_on,
    output logic             tx_stop,
    output logic             stop_irq,
    output logic [CNT_W-1:0] inflight
);

    txq_ctl_t         ctl;
    logic             cnt_empty;
    logic             cnt_full;
    logic             launch;
    logic [CNT_W-1:0] cnt;

    // Counter of frames that have started but have no status yet.
    txq_inflight_cnt #(
        .MAX_INFLIGHT(MAX_INFLIGHT)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (launch),
        .dec   (status_wr),
        .cnt   (cnt),
        .empty (cnt_empty),
        .full  (cnt_full)
    );

    // Control bits and stop interrupt.
    txq_ctl_bits u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .on_set   (host_on_set),
        .stop_set (host_stop_set),
        .drained  (cnt_empty),
        .ctl      (ctl),
        .irq      (stop_irq)
    );

    // Launch decision.
    txq_launch_gate u_gate (
        .ctl       (ctl),
        .sof_ready (sof_ready),
        .full      (cnt_full),
        .launch    (launch)
    );

    assign frame_start = launch;
    assign tx_on       = ctl.on;
    assign tx_stop     = ctl.stop;
    assign inflight    = cnt;

endmodule

// File: rtl/txq_halt_chk.sv
// Module txq_halt_chk
// Property checks for txq_halt_ctrl, attached through bind.
// Assumes the same parameter values as the block it is bound to.
module txq_halt_chk #(
    parameter int MAX_INFLIGHT = 1,
    localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_on_set,
    input logic             host_stop_set,
    input logic             sof_ready,
    input logic             status_wr,
    input logic             frame_start,
    input logic             tx_on,
    input logic             tx_stop,
    input logic             stop_irq,
    input logic [CNT_W-1:0] inflight
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_INFLIGHT);

    p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_on_set |=> tx_on);

    p_status_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == '0) && !frame_start |=> inflight == '0);

    p_no_start_stopping_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop |-> !frame_start);

    p_stop_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop && (inflight != '0) |=> tx_stop && !stop_irq);

    p_stop_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop && (inflight == '0) |=> stop_irq && !tx_stop);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !stop_irq);

    p_enable_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop && (inflight == '0) && host_on_set |=> tx_on);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_MAX);

    p_no_start_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == CNT_MAX) |-> !frame_start);

endmodule

bind txq_halt_ctrl txq_halt_chk #(
    .MAX_INFLIGHT(MAX_INFLIGHT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_on_set   (host_on_set),
    .host_stop_set (host_stop_set),
    .sof_ready     (sof_ready),
    .status_wr     (status_wr),
    .frame_start   (frame_start),
    .tx_on         (tx_on),
    .tx_stop       (tx_stop),
    .stop_irq      (stop_irq),
    .inflight      (inflight)
);

// File: tb/txq_halt_ctrl_tb_top.sv
// Bench for txq_halt_ctrl. A behavioural reference model runs next to the
// design and every output is compared once per clock.
module txq_halt_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXF       = 2;
    localparam int CW         = $clog2(MAXF + 1);
    localparam int WATCHDOG   = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          on_set = 1'b0;
    logic          stop_set = 1'b0;
    logic          sof = 1'b0;
    logic          st_wr = 1'b0;
    logic          fs;
    logic          on_o;
    logic          stop_o;
    logic          irq_o;
    logic [CW-1:0] infl;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    int m_on = 0;
    int m_stop = 0;
    int m_irq = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txq_halt_ctrl #(.MAX_INFLIGHT(MAXF)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_on_set   (on_set),
        .host_stop_set (stop_set),
        .sof_ready     (sof),
        .status_wr     (st_wr),
        .frame_start   (fs),
        .tx_on         (on_o),
        .tx_stop       (stop_o),
        .stop_irq      (irq_o),
        .inflight      (infl)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drives one cycle of inputs, compares all outputs with the model, then
    // advances the model at the clock edge.
    task automatic step(input bit a_on, input bit a_stop, input bit a_sof,
                        input bit a_st, input string req);
        int exp_fs;
        int done;
        @(negedge clk);
        on_set = a_on; stop_set = a_stop; sof = a_sof; st_wr = a_st;
        #1;
        exp_fs = (m_on && !m_stop && a_sof && m_cnt < MAXF) ? 1 : 0;
        check(req, "frame_start", int'(fs), exp_fs);
        check(req, "tx_on", int'(on_o), m_on);
        check(req, "tx_stop", int'(stop_o), m_stop);
        check(req, "stop_irq", int'(irq_o), m_irq);
        check(req, "inflight", int'(infl), m_cnt);
        @(posedge clk);
        done  = (m_stop && m_cnt == 0) ? 1 : 0;
        m_cnt = m_cnt + exp_fs - ((a_st && m_cnt > 0) ? 1 : 0);
        m_irq = done;
        if (done) begin
            m_stop = 0;
            m_on   = 0;
        end else if (a_stop) begin
            m_stop = 1;
        end
        if (a_on) m_on = 1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=0 cycles left", WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        #1;
        check("R1", "tx_on", int'(on_o), 0);
        check("R1", "tx_stop", int'(stop_o), 0);
        check("R1", "stop_irq", int'(irq_o), 0);
        check("R1", "inflight", int'(infl), 0);
        check("R1", "frame_start", int'(fs), 0);

        // R2: enable, then launch frames
        step(0, 0, 1, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(0, 0, 1, 0, "R2");
        // R11: fill up to the limit while sof_ready stays high
        step(0, 0, 1, 0, "R11");
        step(0, 0, 1, 0, "R11");
        step(0, 0, 1, 0, "R11");
        // R3: launch and status write in the same cycle
        step(0, 0, 0, 1, "R3");
        step(0, 0, 1, 1, "R3");
        step(0, 0, 1, 0, "R3");

        // R4/R5: stop with two frames in flight, frame still waiting
        step(0, 1, 1, 0, "R4");
        step(0, 0, 1, 0, "R4");
        step(0, 0, 1, 1, "R5");
        step(0, 0, 1, 0, "R5");
        step(0, 0, 1, 1, "R5");
        step(0, 0, 1, 0, "R5");
        step(0, 0, 1, 0, "R6");
        step(0, 0, 1, 0, "R6");

        // R9: re-enable, the waiting frame launches at once
        step(1, 0, 1, 0, "R9");
        step(0, 0, 1, 0, "R9");
        step(0, 0, 0, 1, "R9");
        step(0, 0, 0, 1, "R9");
        // R3: status write with nothing in flight is ignored
        step(0, 0, 0, 1, "R3");
        step(0, 0, 0, 0, "R3");

        // R7: stop from idle
        step(0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, "R6");

        // R8: enable written in the completion cycle
        step(1, 0, 0, 0, "R8");
        step(0, 1, 0, 0, "R8");
        step(1, 0, 0, 0, "R8");
        step(0, 0, 0, 0, "R8");
        step(0, 0, 1, 0, "R8");
        step(0, 0, 0, 1, "R8");

        // R10: stop written again in the completion cycle
        step(0, 1, 0, 0, "R10");
        step(0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, "R10");
        // stop request while disabled still completes
        step(0, 1, 1, 0, "R7");
        step(0, 0, 1, 0, "R7");
        step(0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule